// File: doc/BRIEF.md
# Instruction Fetch Address Sequencer

This block is the next-address engine of a small hardwired DSP control unit. Each cycle it holds the address of the instruction being fetched and works out, in the same cycle, where the following fetch comes from. There are four possible sources: the incremented program counter, a target field taken from the current instruction, an interrupt vector, and the top of a dedicated hardware return stack. Return addresses live in that stack, which feeds the program counter directly, so calls and returns never touch data memory.

A single-level hardware loop unit holds a start address, an end address and an iteration count. When the fetch address reaches the end address with a nonzero count, the next fetch goes back to the start and the count drops by one, all without spending any cycles. Condition logic tests four status flags so that jumps and calls can be made conditional. Decode, datapath and memories sit outside. The block has no data stream, so every pin is a plain control or status signal without a handshake. `stall` freezes the sequencer for as long as it is high.

Top module: `fetch_seq`

## Requirements
- R1: While `rst_n` is low and after its release, `fetch_addr` is `RESET_ADDR` (default 0), the return stack is empty, the loop count is zero, and `stk_ovf` and `stk_udf` are low.
- R2: Commands on `cmd` are 0 none, 1 jump, 2 call, 3 return, 4 loop setup, and 5 to 7 act as none. With no other source selected, the next `fetch_addr` is the current one plus 1, wrapping modulo 2^AW.
- R3: While `stall` is high, `fetch_addr`, the stack and the loop state hold, `irq` and `cmd` are ignored, and both error pulses stay low.
- R4: `flags` bits are [0] zero, [1] negative, [2] carry, [3] overflow. `cond` codes are 0 always, 1 zero set, 2 zero clear, 3 less (negative xor overflow), 4 greater-or-equal (not less), 5 overflow set, 6 carry set, 7 never. A jump loads `target` when its condition passes and otherwise advances by 1.
- R5: A call whose condition passes pushes the current address plus 1 and loads `target`. A return pops the most recent entry into `fetch_addr`. The stack holds up to 8 entries in last-in, first-out order.
- R6: A loop setup captures start = current address + 1, end = `loop_end` and count = `loop_count`, and advances by 1. Afterwards, whenever `fetch_addr` equals the end with a nonzero count and no higher source is selected, the next address is the start and the count decrements. With a zero count, execution falls through, so the body runs count+1 times.
- R7: A push attempted with 8 entries held is dropped, `stk_ovf` is high for the one cycle after, and the address still changes to the target or the vector.
- R8: A return with the stack empty pops nothing, `stk_udf` is high for the one cycle after, and the next address is chosen as if the command were none.
- R9: An accepted `irq` overrides the current command, which has no effect. It pushes the current `fetch_addr`, which is the instruction that would have run next, and loads `irq_vec`. A later return resumes at that address.
- R10: The order of priority is interrupt, then return or taken jump or call, then loop-back, then +1. A taken branch or return at the loop end leaves the loop count unchanged.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| stall | input | 1 | Freeze sequencer this cycle |
| cmd | input | 3 | Decoded control command for the instruction at `fetch_addr` |
| cond | input | 3 | Condition code for jump and call |
| target | input | AW | Branch or call target from the instruction |
| loop_end | input | AW | Last body address for loop setup |
| loop_count | input | CW | Repeat count for loop setup |
| flags | input | 4 | Status flags {overflow, carry, negative, zero} |
| irq | input | 1 | Interrupt request |
| irq_vec | input | AW | Interrupt vector address |
| fetch_addr | output | AW | Address of the instruction being fetched |
| stk_ovf | output | 1 | One-cycle pulse: push dropped on a full stack |
| stk_udf | output | 1 | One-cycle pulse: pop dropped on an empty stack |

## Verification
Assertions check the rules that hold cycle by cycle: a stall freezes the address, an accepted interrupt lands on the vector, an unconditional jump lands on its target, the stack depth stays within bounds and does not change on a dropped push, and every loop-back lowers the count by exactly one. Only the bench's scenarios can show the longer behaviour. That covers the LIFO order across nested calls, resumption after an interrupt, the exact count+1 body repetitions and the fall-through at zero, and the priority between a branch and a loop-back at the loop end. A behavioural reference model covers these in directed and random sequences.

// File: rtl/seq_pkg.sv
package seq_pkg;
  typedef enum logic [2:0] {
    CMD_NONE = 3'd0,
    CMD_JUMP = 3'd1,
    CMD_CALL = 3'd2,
    CMD_RET  = 3'd3,
    CMD_LOOP = 3'd4
  } cmd_e;

  typedef enum logic [2:0] {
    CC_ALWAYS = 3'd0,
    CC_EQ     = 3'd1,
    CC_NE     = 3'd2,
    CC_LT     = 3'd3,
    CC_GE     = 3'd4,
    CC_VS     = 3'd5,
    CC_CS     = 3'd6,
    CC_NEVER  = 3'd7
  } cc_e;

  localparam int FLG_Z = 0;
  localparam int FLG_N = 1;
  localparam int FLG_C = 2;
  localparam int FLG_V = 3;
  localparam int FLG_W = 4;
endpackage

// File: rtl/cond_eval.sv
module cond_eval
  import seq_pkg::*;
(
  input  logic [2:0]       cond,
  input  logic [FLG_W-1:0] flags,
  output logic             pass
);
  logic lt;
  assign lt = flags[FLG_N] ^ flags[FLG_V];

  always_comb begin
    unique case (cc_e'(cond))
      CC_ALWAYS: pass = 1'b1;
      CC_EQ:     pass = flags[FLG_Z];
      CC_NE:     pass = !flags[FLG_Z];
      CC_LT:     pass = lt;
      CC_GE:     pass = !lt;
      CC_VS:     pass = flags[FLG_V];
      CC_CS:     pass = flags[FLG_C];
      default:   pass = 1'b0;
    endcase
  end
endmodule

// File: rtl/ret_stack.sv
module ret_stack #(
  parameter int AW    = 16,
  parameter int DEPTH = 8
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          push,
  input  logic          pop,
  input  logic [AW-1:0] din,
  output logic [AW-1:0] top,
  output logic          full,
  output logic          empty
);
  localparam int PW = $clog2(DEPTH);

  logic [AW-1:0] mem [DEPTH];
  logic [PW:0]   cnt;
  logic [PW-1:0] top_idx;

  assign full    = (cnt == (PW+1)'(DEPTH));
  assign empty   = (cnt == '0);
  assign top_idx = PW'(cnt - 1'b1);
  assign top     = mem[top_idx];

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      cnt <= '0;
    end else if (push && !full) begin
      mem[cnt[PW-1:0]] <= din;
      cnt <= cnt + 1'b1;
    end else if (pop && !empty) begin
      cnt <= cnt - 1'b1;
    end
  end

  // R5
  depth_bound_chk: assert property (@(posedge clk) disable iff (!rst_n)
    cnt <= (PW+1)'(DEPTH));

  // R7
  full_push_drop_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (push && full && !pop) |=> $stable(cnt));

  // R5
  push_pop_excl_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !(push && pop));
endmodule

// File: rtl/loop_unit.sv
module loop_unit #(
  parameter int AW = 16,
  parameter int CW = 16
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          enable,
  input  logic          set,
  input  logic [AW-1:0] start_in,
  input  logic [AW-1:0] end_in,
  input  logic [CW-1:0] cnt_in,
  input  logic [AW-1:0] pc,
  output logic          back,
  output logic [AW-1:0] start_addr
);
  logic [AW-1:0] end_q;
  logic [CW-1:0] cnt_q;

  assign back = enable && !set && (pc == end_q) && (cnt_q != '0);

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      start_addr <= '0;
      end_q      <= '0;
      cnt_q      <= '0;
    end else if (set) begin
      start_addr <= start_in;
      end_q      <= end_in;
      cnt_q      <= cnt_in;
    end else if (back) begin
      cnt_q <= cnt_q - 1'b1;
    end
  end

  // R6
  loop_dec_chk: assert property (@(posedge clk) disable iff (!rst_n)
    back |=> cnt_q == $past(cnt_q) - 1'b1);

  // R10
  loop_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (!enable && !set) |=> $stable(cnt_q));
endmodule

// File: rtl/fetch_seq.sv
module fetch_seq
  import seq_pkg::*;
#(
  parameter int          AW         = 16,
  parameter int          CW         = 16,
  parameter int          DEPTH      = 8,
  parameter logic [15:0] RESET_ADDR = 16'h0000
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             stall,
  input  logic [2:0]       cmd,
  input  logic [2:0]       cond,
  input  logic [AW-1:0]    target,
  input  logic [AW-1:0]    loop_end,
  input  logic [CW-1:0]    loop_count,
  input  logic [FLG_W-1:0] flags,
  input  logic             irq,
  input  logic [AW-1:0]    irq_vec,
  output logic [AW-1:0]    fetch_addr,
  output logic             stk_ovf,
  output logic             stk_udf
);
  logic [AW-1:0] pc, pc_inc, pc_nxt, stk_top, push_data, loop_start;
  logic adv, irq_go, cc_pass, is_ret, is_br, is_call;
  logic ret_go, br_go, loop_en, loop_set, loop_back;
  logic push_req, pop_req, stk_full, stk_empty;
  cmd_e cmd_t;

  assign cmd_t   = cmd_e'(cmd);
  assign pc_inc  = pc + 1'b1;
  assign adv     = !stall;
  assign irq_go  = adv && irq;
  assign is_ret  = (cmd_t == CMD_RET);
  assign is_call = (cmd_t == CMD_CALL);
  assign is_br   = ((cmd_t == CMD_JUMP) || is_call) && cc_pass;

  assign pop_req  = adv && !irq && is_ret;
  assign ret_go   = pop_req && !stk_empty;
  assign br_go    = adv && !irq && is_br;
  assign push_req = irq_go || (br_go && is_call);
  assign push_data = irq_go ? pc : pc_inc;
  assign loop_en  = adv && !irq && !ret_go && !br_go;
  assign loop_set = loop_en && (cmd_t == CMD_LOOP);

  cond_eval u_cond (
    .cond  (cond),
    .flags (flags),
    .pass  (cc_pass)
  );

  ret_stack #(.AW(AW), .DEPTH(DEPTH)) u_stack (
    .clk   (clk),
    .rst_n (rst_n),
    .push  (push_req),
    .pop   (pop_req),
    .din   (push_data),
    .top   (stk_top),
    .full  (stk_full),
    .empty (stk_empty)
  );

  loop_unit #(.AW(AW), .CW(CW)) u_loop (
    .clk        (clk),
    .rst_n      (rst_n),
    .enable     (loop_en),
    .set        (loop_set),
    .start_in   (pc_inc),
    .end_in     (loop_end),
    .cnt_in     (loop_count),
    .pc         (pc),
    .back       (loop_back),
    .start_addr (loop_start)
  );

  always_comb begin
    if (irq_go)         pc_nxt = irq_vec;
    else if (ret_go)    pc_nxt = stk_top;
    else if (br_go)     pc_nxt = target;
    else if (loop_back) pc_nxt = loop_start;
    else                pc_nxt = pc_inc;
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      pc      <= AW'(RESET_ADDR);
      stk_ovf <= 1'b0;
      stk_udf <= 1'b0;
    end else begin
      if (adv) pc <= pc_nxt;
      stk_ovf <= push_req && stk_full;
      stk_udf <= pop_req && stk_empty;
    end
  end

  assign fetch_addr = pc;

  // R3
  stall_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    stall |=> $stable(fetch_addr));

  // R9
  irq_vector_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (irq && !stall) |=> fetch_addr == $past(irq_vec));

  // R4
  jump_always_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (!stall && !irq && cmd == 3'd1 && cond == 3'd0) |=> fetch_addr == $past(target));

  // R3
  stall_quiet_chk: assert property (@(posedge clk) disable iff (!rst_n)
    stall |=> (!stk_ovf && !stk_udf));
endmodule

// File: tb/fetch_seq_tb_top.sv
`timescale 1ns/1ps
module fetch_seq_tb_top;
  localparam int AW = 16;
  localparam int CW = 16;
  localparam int MASK = 16'hFFFF;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic stall = 1'b0;
  logic [2:0] cmd = 3'd0;
  logic [2:0] cond = 3'd0;
  logic [AW-1:0] target = '0;
  logic [AW-1:0] loop_end = '0;
  logic [CW-1:0] loop_count = '0;
  logic [3:0] flags = 4'd0;
  logic irq = 1'b0;
  logic [AW-1:0] irq_vec = '0;
  logic [AW-1:0] fetch_addr;
  logic stk_ovf, stk_udf;

  always #5 clk = ~clk;

  fetch_seq dut_i (
    .clk(clk), .rst_n(rst_n), .stall(stall), .cmd(cmd), .cond(cond),
    .target(target), .loop_end(loop_end), .loop_count(loop_count),
    .flags(flags), .irq(irq), .irq_vec(irq_vec),
    .fetch_addr(fetch_addr), .stk_ovf(stk_ovf), .stk_udf(stk_udf)
  );

  int n_checks = 0;
  int n_err = 0;
  bit finished = 0;

  // reference model state
  int m_pc, m_ls, m_le, m_lc;
  int m_q[$];
  bit m_ovf, m_udf;
  string m_tag;

  task automatic check(input string tag, input int act, input int exp);
    n_checks++;
    if (act != exp) begin
      n_err++;
      $display("FAIL %s: actual=%0h expected=%0h at %0t", tag, act, exp, $time);
    end
  endtask

  function automatic bit cc_ok(input int c, input logic [3:0] f);
    bit lt = f[1] ^ f[3];
    case (c)
      0: return 1;
      1: return f[0];
      2: return !f[0];
      3: return lt;
      4: return !lt;
      5: return f[3];
      6: return f[2];
      default: return 0;
    endcase
  endfunction

  task automatic model_reset();
    m_pc = 0; m_ls = 0; m_le = 0; m_lc = 0;
    m_q.delete(); m_ovf = 0; m_udf = 0; m_tag = "R1";
  endtask

  // one clock: model computes next state from current inputs, then compare
  task automatic tick();
    bit sel = 0;
    int nxt;
    m_ovf = 0; m_udf = 0;
    if (stall) begin
      m_tag = "R3";
    end else begin
      nxt = (m_pc + 1) & MASK;
      m_tag = "R2";
      if (irq) begin
        m_tag = "R9";
        if (m_q.size() == 8) begin m_ovf = 1; m_tag = "R7"; end
        else m_q.push_back(m_pc);
        nxt = int'(irq_vec); sel = 1;
      end else if (cmd == 3) begin
        if (m_q.size() == 0) begin m_udf = 1; m_tag = "R8"; end
        else begin nxt = m_q.pop_back(); sel = 1; m_tag = "R5"; end
      end else if ((cmd == 1 || cmd == 2) && cc_ok(int'(cond), flags)) begin
        m_tag = (cmd == 1) ? "R4" : "R5";
        if (cmd == 2) begin
          if (m_q.size() == 8) begin m_ovf = 1; m_tag = "R7"; end
          else m_q.push_back((m_pc + 1) & MASK);
        end
        nxt = int'(target); sel = 1;
      end
      if (!sel) begin
        if (cmd == 4) begin
          m_ls = (m_pc + 1) & MASK; m_le = int'(loop_end); m_lc = int'(loop_count);
          m_tag = "R6";
        end else if (m_pc == m_le && m_lc != 0) begin
          nxt = m_ls; m_lc = m_lc - 1; m_tag = "R6";
        end
      end else if (m_pc == m_le && m_lc != 0) begin
        m_tag = "R10";
      end
      m_pc = nxt;
    end
    @(negedge clk);
    check({m_tag, " fetch_addr"}, int'(fetch_addr), m_pc);
    check({m_tag, " stk_ovf"}, int'(stk_ovf), int'(m_ovf));
    check({m_tag, " stk_udf"}, int'(stk_udf), int'(m_udf));
  endtask

  task automatic idle();
    cmd = 3'd0; irq = 1'b0; stall = 1'b0;
  endtask

  task automatic do_cmd(input int c, input int cc, input int tgt);
    idle(); cmd = 3'(c); cond = 3'(cc); target = AW'(tgt); tick();
  endtask

  initial begin : watchdog
    #2000000;
    if (!finished) begin
      n_err++; n_checks++;
      $display("FAIL watchdog: actual=timeout expected=done");
      $display("  Result: errors=%0d of %0d checks", n_err, n_checks);
      $finish;
    end
  end

  initial begin : main
    int visits;
    model_reset();
    repeat (3) @(negedge clk);
    // R1 reset state
    check("R1 reset fetch_addr", int'(fetch_addr), 0);
    check("R1 reset stk_ovf", int'(stk_ovf), 0);
    check("R1 reset stk_udf", int'(stk_udf), 0);
    rst_n = 1'b1;
    tick();
    // R2 sequential
    repeat (4) do_cmd(0, 0, 0);
    do_cmd(6, 0, 16'h1234);
    // R4 jumps under each code, pass and fail
    for (int c = 0; c < 8; c++) begin
      for (int f = 0; f < 16; f += 5) begin
        flags = 4'(f);
        do_cmd(1, c, 16'h0100 + c * 16 + f);
      end
    end
    flags = 4'd0;
    // R5 nested calls and returns
    do_cmd(2, 0, 16'h0200);
    do_cmd(0, 0, 0);
    do_cmd(2, 0, 16'h0300);
    do_cmd(3, 0, 0);
    do_cmd(3, 0, 0);
    // R8 underflow
    do_cmd(3, 0, 0);
    do_cmd(0, 0, 0);
    // R7 overflow: 9 calls
    for (int i = 0; i < 9; i++) do_cmd(2, 0, 16'h0400 + i * 8);
    do_cmd(0, 0, 0);
    // R7 irq with full stack
    idle(); irq = 1'b1; irq_vec = 16'h0F00; cmd = 3'd1; tick();
    for (int i = 0; i < 9; i++) do_cmd(3, 0, 0);
    // R9 interrupt overrides call, later resume
    do_cmd(1, 0, 16'h0500);
    idle(); irq = 1'b1; irq_vec = 16'h0E00; cmd = 3'd2; target = 16'h0777; tick();
    do_cmd(0, 0, 0);
    do_cmd(3, 0, 0);
    check("R9 resume address", int'(fetch_addr), 16'h0500);
    // R3 stall holds, irq ignored
    idle(); stall = 1'b1; irq = 1'b1; cmd = 3'd3; tick(); tick();
    idle(); tick();
    // R6 loop count 3 body runs 4 times
    do_cmd(1, 0, 16'h0600);
    idle(); cmd = 3'd4; loop_end = 16'h0603; loop_count = 16'd3; tick();
    visits = 0;
    for (int i = 0; i < 14; i++) begin
      if (fetch_addr == 16'h0601) visits++;
      do_cmd(0, 0, 0);
    end
    check("R6 body repetitions", visits, 4);
    // R6 count zero falls through
    do_cmd(1, 0, 16'h0700);
    idle(); cmd = 3'd4; loop_end = 16'h0701; loop_count = 16'd0; tick();
    do_cmd(0, 0, 0);
    do_cmd(0, 0, 0);
    check("R6 zero count falls through", int'(fetch_addr), 16'h0703);
    // R10 jump at loop end wins, count kept
    do_cmd(1, 0, 16'h0800);
    idle(); cmd = 3'd4; loop_end = 16'h0802; loop_count = 16'd1; tick();
    do_cmd(0, 0, 0);
    do_cmd(1, 0, 16'h0802);
    do_cmd(1, 0, 16'h0850);
    check("R10 branch over loop-back", int'(fetch_addr), 16'h0850);
    do_cmd(1, 0, 16'h0802);
    do_cmd(0, 0, 0);
    check("R10 loop count kept", int'(fetch_addr), 16'h0801);
    // R2 wrap
    do_cmd(1, 0, 16'hFFFE);
    do_cmd(0, 0, 0);
    do_cmd(0, 0, 0);
    check("R2 wrap", int'(fetch_addr), 0);
    // random traffic against the model
    for (int i = 0; i < 3000; i++) begin
      int r = int'($urandom_range(0, 99));
      idle();
      cmd = 3'($urandom_range(0, 7));
      cond = 3'($urandom_range(0, 7));
      flags = 4'($urandom_range(0, 15));
      target = AW'($urandom_range(0, 63));
      loop_end = fetch_addr + AW'($urandom_range(1, 4));
      loop_count = CW'($urandom_range(0, 3));
      irq = (r < 4);
      irq_vec = AW'($urandom_range(64, 80));
      stall = (r > 90);
      tick();
    end
    finished = 1;
    $display("  Result: errors=%0d of %0d checks", n_err, n_checks);
    $finish;
  end
endmodule